// File: doc/BRIEF.md
# Host Flash Write/Erase Gateway

This block sits between an external host bus and an on-chip flash that is shared with a local core. It decides whether a host write may reach the flash. If it may, it turns the write into either a byte-program or a page-erase command. It then tracks the command until the flash reports that it has finished. A write goes through only when three conditions hold together: the host-side write enable for the target region is set, the core-side write enable for that region is set, and the core's lock bit is set. Host reads need the host-side and core-side read enables for the region, but the lock bit plays no part in a read.

The host sees a small control register and a status register. The control register holds the erase-mode bit. The status register holds a busy flag and two sticky error flags, one for failed erases and one for failed programs. The core sees the same busy indication on a dedicated output. After the core clears its lock, it must wait for that output to drop before it touches the flash itself.

On the flash side the gateway sends a one-cycle command strobe with an operation code, an address and data. The flash answers with a busy level and an error level. The error level is sampled when busy falls.

Top module: `hflash_gate`

## Requirements
- R1: A host memory write is forwarded to the flash only if `core_lock` is 1 at the clock edge where the write is presented. With the lock at 0 the write is dropped: no `fl_req`, and busy stays 0.
- R2: The flash is split into regions of 2^RGN_BITS bytes (4 KB by default). The region index is `hmem_addr[AW-1:RGN_BITS]`. A write is accepted only if bit `index` of both `host_wen` and `core_wen` is 1. Otherwise it is dropped silently.
- R3: A host memory read is answered one cycle later with `hmem_rvalid`=1. The read is permitted when bit `index` of both `host_ren` and `core_ren` is 1 and the gateway is not busy. In that case `fl_rd` pulses and `hmem_rdata` returns `fl_rdata`. Otherwise `fl_rd` stays low and `hmem_rdata` is 0. `core_lock` does not affect reads.
- R4: Erase mode is bit 0 of the control register (`hreg_sel`=0). When it is 1, an accepted write issues `fl_op`=1 (erase). `fl_addr` is the write address with its low PAGE_BITS bits forced to 0 (512-byte pages by default). The written data does not matter.
- R5: When erase mode is 0, an accepted write issues `fl_op`=0 (program), with `fl_addr`=`hmem_addr` and `fl_wdata`=`hmem_wdata`.
- R6: Status bit 0 (busy) and `core_flash_busy` rise at the acceptance edge. `fl_req` is high for the single following cycle. Busy falls at the first edge where `fl_busy` is 0 after having been seen at 1. With a flash that stays busy for L cycles, busy lasts L+2 cycles.
- R7: At completion, if `fl_err` is 1, status bit 1 is set for an erase or status bit 2 is set for a program. Each flag stays set until it is cleared.
- R8: Writing the status register (`hreg_sel`=1) with a 1 in bit 1 or bit 2 clears that flag. A 0 in a bit leaves that flag unchanged.
- R9: Both error flags clear at the edge where a new write is accepted.
- R10: A write presented while busy is dropped. It issues no command, and it changes neither the operation in progress nor the error outcome of that operation.
- R11: Clearing `core_lock` while an operation is under way does not abort it. `core_flash_busy` stays 1 until that operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hreg_sel | input | 1 | Register select: 0 control, 1 status |
| hreg_we | input | 1 | Host register write strobe |
| hreg_wdata | input | 3 | Host register write data |
| hreg_rdata | output | 3 | Selected register contents (combinational) |
| hmem_req | input | 1 | Host memory access request |
| hmem_we | input | 1 | 1 write, 0 read |
| hmem_addr | input | AW | Host memory byte address |
| hmem_wdata | input | DW | Host write data |
| hmem_rvalid | output | 1 | Read answer valid |
| hmem_rdata | output | DW | Read answer data |
| host_wen | input | NRGN | Host-side write enable per region |
| host_ren | input | NRGN | Host-side read enable per region |
| core_wen | input | NRGN | Core-side write enable per region |
| core_ren | input | NRGN | Core-side read enable per region |
| core_lock | input | 1 | Core lock permitting host writes |
| core_flash_busy | output | 1 | Operation in progress, seen by the core |
| fl_req | output | 1 | One-cycle program/erase command |
| fl_op | output | 1 | 0 program, 1 erase |
| fl_rd | output | 1 | Read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash program data |
| fl_rdata | input | DW | Flash read data |
| fl_busy | input | 1 | Flash operation in progress |
| fl_err | input | 1 | Flash failure, valid when busy falls |

## Verification
The hardest case to reach is a second write that arrives while an operation is still in flight. That write passes every protection check and would be accepted if the gateway were idle. The bench issues such a write in the middle of a failing program. It then confirms three things: only one command reached the flash, the address of that command was not changed, and the error flag of the first operation still appears. A similar case is a lock withdrawal between the command cycle and the completion, which must not cut the busy window short. A behavioural model runs in parallel and predicts busy, the command fields, read answers and the status bits on every cycle.

// File: rtl/hfg_pkg.sv
package hfg_pkg;

   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } hfg_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } hfg_sq_e;

   localparam int STW       = 3;
   localparam int ST_BUSY   = 0;
   localparam int ST_EERR   = 1;
   localparam int ST_PERR   = 2;
   localparam int CTL_EMODE = 0;

endpackage

// File: rtl/hfg_region_check.sv
module hfg_region_check #(
   parameter int AW       = 16,
   parameter int RGN_BITS = 12,
   localparam int RW      = AW - RGN_BITS,
   localparam int NRGN    = 1 << RW
) (
   input  logic [RW-1:0]   rgn,
   input  logic [NRGN-1:0] side_host,
   input  logic [NRGN-1:0] side_core,
   output logic            ok
);

   logic [NRGN-1:0] both_on;

   for (genvar gi = 0; gi < NRGN; gi++) begin : g_rgn
      assign both_on[gi] = side_host[gi] & side_core[gi];
   end

   assign ok = both_on[rgn];

endmodule

// File: rtl/hfg_seq.sv
module hfg_seq
   import hfg_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int PAGE_BITS = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  hfg_op_e       start_op,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_data,
   input  logic          fl_busy,
   output logic          fl_req,
   output hfg_op_e       cmd_op,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          busy,
   output logic          done
);

   hfg_sq_e       st;
   logic          seen_busy;
   logic [AW-1:0] page_addr;

   if (PAGE_BITS > 0) begin : g_align
      assign page_addr = {start_addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
   end else begin : g_noalign
      assign page_addr = start_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         seen_busy <= 1'b0;
         cmd_op    <= OP_PROG;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (start) begin
                  st        <= SQ_ISSUE;
                  seen_busy <= 1'b0;
                  cmd_op    <= start_op;
                  cmd_addr  <= (start_op == OP_ERASE) ? page_addr : start_addr;
                  cmd_data  <= start_data;
               end
            end
            SQ_ISSUE: st <= SQ_WAIT;
            SQ_WAIT: begin
               if (fl_busy)        seen_busy <= 1'b1;
               else if (seen_busy) st        <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign fl_req = (st == SQ_ISSUE);
   assign busy   = (st != SQ_IDLE);
   assign done   = (st == SQ_WAIT) && seen_busy && !fl_busy;

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |=> !fl_req) else $error("command strobe longer than one cycle"); // R6

   AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fl_busy) |=> busy) else $error("busy dropped while flash busy"); // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy) else $error("completion did not return to idle"); // R6

endmodule

// File: rtl/hfg_status.sv
module hfg_status
   import hfg_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_sel,
   input  logic           reg_we,
   input  logic [STW-1:0] reg_wdata,
   input  logic           start,
   input  logic           done,
   input  hfg_op_e        done_op,
   input  logic           fl_err,
   input  logic           busy,
   output hfg_op_e        mode_op,
   output logic [STW-1:0] reg_rdata
);

   logic emode;
   logic eerr;
   logic perr;
   logic ctl_wr;
   logic sta_wr;

   assign ctl_wr = reg_we && !reg_sel;
   assign sta_wr = reg_we &&  reg_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emode <= 1'b0;
         eerr  <= 1'b0;
         perr  <= 1'b0;
      end else begin
         if (ctl_wr) emode <= reg_wdata[CTL_EMODE];
         if (start) begin
            eerr <= 1'b0;
            perr <= 1'b0;
         end else begin
            if (sta_wr && reg_wdata[ST_EERR]) eerr <= 1'b0;
            if (sta_wr && reg_wdata[ST_PERR]) perr <= 1'b0;
            if (done && fl_err) begin
               if (done_op == OP_ERASE) eerr <= 1'b1;
               else                     perr <= 1'b1;
            end
         end
      end
   end

   assign mode_op = emode ? OP_ERASE : OP_PROG;

   always_comb begin
      reg_rdata = '0;
      if (reg_sel) begin
         reg_rdata[ST_BUSY] = busy;
         reg_rdata[ST_EERR] = eerr;
         reg_rdata[ST_PERR] = perr;
      end else begin
         reg_rdata[CTL_EMODE] = emode;
      end
   end

   AST_ERR_CLR_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!eerr && !perr)) else $error("errors survived a new start"); // R9

   AST_EERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (sta_wr && reg_wdata[ST_EERR] && !done) |=> !eerr) else $error("erase error not cleared"); // R8

   AST_PERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (sta_wr && reg_wdata[ST_PERR] && !done) |=> !perr) else $error("program error not cleared"); // R8

endmodule

// File: rtl/hflash_gate.sv
module hflash_gate
   import hfg_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int RGN_BITS  = 12,
   parameter int PAGE_BITS = 9,
   localparam int RW       = AW - RGN_BITS,
   localparam int NRGN     = 1 << RW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hreg_sel,
   input  logic            hreg_we,
   input  logic [STW-1:0]  hreg_wdata,
   output logic [STW-1:0]  hreg_rdata,
   input  logic            hmem_req,
   input  logic            hmem_we,
   input  logic [AW-1:0]   hmem_addr,
   input  logic [DW-1:0]   hmem_wdata,
   output logic            hmem_rvalid,
   output logic [DW-1:0]   hmem_rdata,
   input  logic [NRGN-1:0] host_wen,
   input  logic [NRGN-1:0] host_ren,
   input  logic [NRGN-1:0] core_wen,
   input  logic [NRGN-1:0] core_ren,
   input  logic            core_lock,
   output logic            core_flash_busy,
   output logic            fl_req,
   output logic            fl_op,
   output logic            fl_rd,
   output logic [AW-1:0]   fl_addr,
   output logic [DW-1:0]   fl_wdata,
   input  logic [DW-1:0]   fl_rdata,
   input  logic            fl_busy,
   input  logic            fl_err
);

   initial begin
      assert (RGN_BITS > 0 && RGN_BITS < AW) else $error("RGN_BITS out of range");
      assert (PAGE_BITS >= 0 && PAGE_BITS <= RGN_BITS) else $error("PAGE_BITS out of range");
      assert (RW <= 8) else $error("too many regions");
      assert (DW > 0) else $error("DW must be positive");
   end

   logic [RW-1:0] rgn;
   logic          wr_region_ok;
   logic          rd_region_ok;
   logic          busy;
   logic          accept;
   logic          done;
   hfg_op_e       mode_op;
   hfg_op_e       cmd_op;
   logic [AW-1:0] cmd_addr;

   assign rgn = hmem_addr[AW-1:RGN_BITS];

   hfg_region_check #(.AW(AW), .RGN_BITS(RGN_BITS)) u_wr_chk (
      .rgn       (rgn),
      .side_host (host_wen),
      .side_core (core_wen),
      .ok        (wr_region_ok)
   );

   hfg_region_check #(.AW(AW), .RGN_BITS(RGN_BITS)) u_rd_chk (
      .rgn       (rgn),
      .side_host (host_ren),
      .side_core (core_ren),
      .ok        (rd_region_ok)
   );

   assign accept = hmem_req && hmem_we && wr_region_ok && core_lock && !busy;

   hfg_seq #(.AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_op   (mode_op),
      .start_addr (hmem_addr),
      .start_data (hmem_wdata),
      .fl_busy    (fl_busy),
      .fl_req     (fl_req),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .cmd_data   (fl_wdata),
      .busy       (busy),
      .done       (done)
   );

   hfg_status u_sta (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (hreg_sel),
      .reg_we    (hreg_we),
      .reg_wdata (hreg_wdata),
      .start     (accept),
      .done      (done),
      .done_op   (cmd_op),
      .fl_err    (fl_err),
      .busy      (busy),
      .mode_op   (mode_op),
      .reg_rdata (hreg_rdata)
   );

   assign fl_op           = cmd_op;
   assign fl_rd           = hmem_req && !hmem_we && rd_region_ok && !busy;
   assign fl_addr         = fl_req ? cmd_addr : hmem_addr;
   assign core_flash_busy = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hmem_rvalid <= 1'b0;
         hmem_rdata  <= '0;
      end else begin
         hmem_rvalid <= hmem_req && !hmem_we;
         hmem_rdata  <= fl_rd ? fl_rdata : '0;
      end
   end

   AST_NO_FWD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (hmem_req && hmem_we && !core_lock && !busy) |=> !fl_req) else $error("write forwarded without lock"); // R1

   AST_NO_FWD_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (hmem_req && hmem_we && !wr_region_ok && !busy) |=> !fl_req) else $error("write forwarded to protected region"); // R2

   AST_READ_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (hmem_req && !hmem_we && !rd_region_ok) |=> (hmem_rvalid && hmem_rdata == '0)) else $error("denied read leaked data"); // R3

   AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hmem_req && hmem_we) |=> !fl_req) else $error("write accepted while busy"); // R10

   AST_LOCK_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fl_busy && !core_lock) |=> core_flash_busy) else $error("lock clear aborted operation"); // R11

endmodule

// File: tb/hflash_gate_tb_top.sv
module hflash_gate_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 16;
   localparam int DW   = 8;
   localparam int NRGN = 16;
   localparam int FLAT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hreg_sel = 1'b1;
   logic          hreg_we = 1'b0;
   logic [2:0]    hreg_wdata = '0;
   logic [2:0]    hreg_rdata;
   logic          hmem_req = 1'b0;
   logic          hmem_we = 1'b0;
   logic [AW-1:0] hmem_addr = '0;
   logic [DW-1:0] hmem_wdata = '0;
   logic          hmem_rvalid;
   logic [DW-1:0] hmem_rdata;
   logic [NRGN-1:0] host_wen = '1, host_ren = '1, core_wen = '1, core_ren = '1;
   logic          core_lock = 1'b0;
   logic          core_flash_busy;
   logic          fl_req, fl_op, fl_rd;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_wdata;
   logic [DW-1:0] fl_rdata;
   logic          fl_busy = 1'b0;
   logic          fl_err = 1'b0;

   int total = 0;
   int bad = 0;
   int nreq = 0;
   int nrd = 0;
   int fcnt = 0;
   bit next_err = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hflash_gate dut_i (
      .clk(clk), .rst_n(rst_n),
      .hreg_sel(hreg_sel), .hreg_we(hreg_we), .hreg_wdata(hreg_wdata), .hreg_rdata(hreg_rdata),
      .hmem_req(hmem_req), .hmem_we(hmem_we), .hmem_addr(hmem_addr), .hmem_wdata(hmem_wdata),
      .hmem_rvalid(hmem_rvalid), .hmem_rdata(hmem_rdata),
      .host_wen(host_wen), .host_ren(host_ren), .core_wen(core_wen), .core_ren(core_ren),
      .core_lock(core_lock), .core_flash_busy(core_flash_busy),
      .fl_req(fl_req), .fl_op(fl_op), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_rdata(fl_rdata), .fl_busy(fl_busy), .fl_err(fl_err)
   );

   function automatic logic [7:0] fdat(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   assign fl_rdata = fdat(fl_addr);

   // flash model
   always @(posedge clk) begin
      if (fl_req) begin
         nreq    <= nreq + 1;
         fl_busy <= 1'b1;
         fcnt    <= FLAT;
         fl_err  <= next_err;
      end else if (fl_busy) begin
         if (fcnt <= 1) fl_busy <= 1'b0;
         else           fcnt    <= fcnt - 1;
      end
      if (fl_rd) nrd <= nrd + 1;
   end

   // reference model
   bit          m_busy, m_seen, m_issue, m_op, m_emode, m_eerr, m_perr, m_rvalid;
   logic [15:0] m_addr;
   logic [7:0]  m_data, m_rdata;

   always @(posedge clk or negedge rst_n) begin : mdl
      bit acc, rdok;
      if (!rst_n) begin
         m_busy <= 0; m_seen <= 0; m_issue <= 0; m_op <= 0; m_emode <= 0;
         m_eerr <= 0; m_perr <= 0; m_rvalid <= 0; m_addr <= 0; m_data <= 0; m_rdata <= 0;
      end else begin
         acc  = hmem_req && hmem_we && !m_busy && core_lock &&
                host_wen[hmem_addr[15:12]] && core_wen[hmem_addr[15:12]];
         rdok = host_ren[hmem_addr[15:12]] && core_ren[hmem_addr[15:12]];
         if (hreg_we && !hreg_sel) m_emode <= hreg_wdata[0];
         if (hreg_we && hreg_sel && hreg_wdata[1]) m_eerr <= 0;
         if (hreg_we && hreg_sel && hreg_wdata[2]) m_perr <= 0;
         if (m_busy && !m_issue) begin
            if (fl_busy) m_seen <= 1;
            else if (m_seen) begin
               m_busy <= 0;
               if (fl_err) begin
                  if (m_op) m_eerr <= 1; else m_perr <= 1;
               end
            end
         end
         m_issue <= acc;
         if (acc) begin
            m_busy <= 1; m_seen <= 0; m_op <= m_emode;
            m_addr <= m_emode ? {hmem_addr[15:9], 9'd0} : hmem_addr;
            m_data <= hmem_wdata;
            m_eerr <= 0; m_perr <= 0;
         end
         m_rvalid <= hmem_req && !hmem_we;
         m_rdata  <= (hmem_req && !hmem_we && rdok && !m_busy) ? fdat(hmem_addr) : 8'h00;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(core_flash_busy == m_busy, "R6 busy", core_flash_busy, m_busy);
         chk(fl_req == m_issue, "R5 command strobe", fl_req, m_issue);
         if (m_issue) begin
            chk(fl_op == m_op, "R4 op", fl_op, m_op);
            chk(fl_addr == m_addr, "R4 address", fl_addr, m_addr);
            if (!m_op) chk(fl_wdata == m_data, "R5 data", fl_wdata, m_data);
         end
         chk(hmem_rvalid == m_rvalid, "R3 rvalid", hmem_rvalid, m_rvalid);
         chk(hmem_rdata == m_rdata, "R3 rdata", hmem_rdata, m_rdata);
         if (hreg_sel)
            chk(hreg_rdata == {m_perr, m_eerr, m_busy}, "R7 status", hreg_rdata, {m_perr, m_eerr, m_busy});
         else
            chk(hreg_rdata == {2'b00, m_emode}, "R4 control", hreg_rdata, {2'b00, m_emode});
      end
   end

   task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); #2;
      hmem_req = 1; hmem_we = 1; hmem_addr = a; hmem_wdata = d;
      @(negedge clk); #2;
      hmem_req = 0; hmem_we = 0;
   endtask

   task automatic host_rd(input logic [15:0] a);
      @(negedge clk); #2;
      hmem_req = 1; hmem_we = 0; hmem_addr = a;
      @(negedge clk); #2;
      hmem_req = 0;
   endtask

   task automatic reg_wr(input logic sel, input logic [2:0] d);
      @(negedge clk); #2;
      hreg_sel = sel; hreg_we = 1; hreg_wdata = d;
      @(negedge clk); #2;
      hreg_we = 0; hreg_sel = 1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && core_flash_busy; i++) begin
         @(negedge clk); #2;
      end
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      int n0, r0, cyc;
      repeat (4) @(negedge clk);
      #2;
      chk(hreg_rdata == 3'b000, "R6 reset status", hreg_rdata, 0);
      chk(fl_req == 0 && core_flash_busy == 0, "R6 reset idle", {fl_req, core_flash_busy}, 0);
      rst_n = 1;
      core_lock = 1;
      @(negedge clk); #2;

      // R5 program
      host_wr(16'h1234, 8'hA5);
      chk(fl_req == 1 && fl_op == 0, "R5 program issued", {fl_req, fl_op}, 2);
      chk(fl_addr == 16'h1234, "R5 program address", fl_addr, 16'h1234);
      chk(fl_wdata == 8'hA5, "R5 program data", fl_wdata, 8'hA5);
      wait_idle();

      // R6 busy window length
      host_wr(16'h1300, 8'h01);
      cyc = 0;
      while (core_flash_busy && cyc < 50) begin
         cyc++;
         @(negedge clk); #2;
      end
      chk(cyc == FLAT + 2, "R6 busy length", cyc, FLAT + 2);

      // R4 erase with page alignment
      reg_wr(1'b0, 3'b001);
      hreg_sel = 0; #1;
      chk(hreg_rdata == 3'b001, "R4 control readback", hreg_rdata, 1);
      hreg_sel = 1;
      host_wr(16'h2345, 8'h77);
      chk(fl_req == 1 && fl_op == 1, "R4 erase issued", {fl_req, fl_op}, 3);
      chk(fl_addr == 16'h2200, "R4 erase page address", fl_addr, 16'h2200);
      wait_idle();

      // R7 erase error
      next_err = 1;
      host_wr(16'h2400, 8'h00);
      wait_idle();
      chk(hreg_rdata == 3'b010, "R7 erase error flag", hreg_rdata, 3'b010);

      // R9 new start clears errors
      next_err = 0;
      reg_wr(1'b0, 3'b000);
      host_wr(16'h1010, 8'h5A);
      chk(hreg_rdata == 3'b001, "R9 errors cleared at start", hreg_rdata, 3'b001);
      wait_idle();

      // R7 program error
      next_err = 1;
      host_wr(16'h1011, 8'h5B);
      wait_idle();
      chk(hreg_rdata == 3'b100, "R7 program error flag", hreg_rdata, 3'b100);

      // R8 write-one-to-clear
      reg_wr(1'b1, 3'b010);
      chk(hreg_rdata == 3'b100, "R8 zero leaves flag", hreg_rdata, 3'b100);
      reg_wr(1'b1, 3'b100);
      chk(hreg_rdata == 3'b000, "R8 one clears flag", hreg_rdata, 3'b000);
      next_err = 0;

      // R1 lock gating
      core_lock = 0;
      n0 = nreq;
      host_wr(16'h1100, 8'h22);
      chk(fl_req == 0 && core_flash_busy == 0, "R1 unlocked write dropped", {fl_req, core_flash_busy}, 0);
      repeat (3) @(negedge clk);
      chk(nreq == n0, "R1 no command", nreq, n0);
      core_lock = 1;

      // R2 region protection, each side
      host_wen[3] = 0;
      host_wr(16'h3010, 8'h33);
      chk(fl_req == 0, "R2 host side blocks", fl_req, 0);
      host_wen[3] = 1; core_wen[3] = 0;
      host_wr(16'h3010, 8'h33);
      chk(fl_req == 0, "R2 core side blocks", fl_req, 0);
      chk(nreq == n0, "R2 no command", nreq, n0);
      host_wr(16'h4010, 8'h44);
      chk(fl_req == 1 && fl_addr == 16'h4010, "R2 other region passes", fl_addr, 16'h4010);
      wait_idle();
      core_wen[3] = 1;

      // R10 write while busy, with failing first operation
      next_err = 1;
      n0 = nreq;
      host_wr(16'h5000, 8'h11);
      host_wr(16'h5100, 8'h22);
      chk(fl_req == 0 && core_flash_busy == 1, "R10 busy write rejected", {fl_req, core_flash_busy}, 1);
      wait_idle();
      chk(nreq == n0 + 1, "R10 single command", nreq, n0 + 1);
      chk(hreg_rdata == 3'b100, "R10 outcome kept", hreg_rdata, 3'b100);
      next_err = 0;
      reg_wr(1'b1, 3'b110);

      // R3 reads
      r0 = nrd;
      host_rd(16'h1234);
      chk(hmem_rvalid == 1 && hmem_rdata == fdat(16'h1234), "R3 permitted read", hmem_rdata, fdat(16'h1234));
      host_ren[1] = 0;
      host_rd(16'h1234);
      chk(hmem_rvalid == 1 && hmem_rdata == 0, "R3 host read disable", hmem_rdata, 0);
      host_ren[1] = 1; core_ren[1] = 0;
      host_rd(16'h1234);
      chk(hmem_rdata == 0, "R3 core read disable", hmem_rdata, 0);
      chk(nrd == r0 + 1, "R3 read strobes", nrd, r0 + 1);
      core_ren[1] = 1; core_lock = 0;
      host_rd(16'h1ABC);
      chk(hmem_rdata == fdat(16'h1ABC), "R3 lock ignored for reads", hmem_rdata, fdat(16'h1ABC));
      core_lock = 1;
      host_wr(16'h6000, 8'h01);
      host_rd(16'h6000);
      chk(hmem_rvalid == 1 && hmem_rdata == 0, "R3 read while busy", hmem_rdata, 0);
      wait_idle();

      // R11 lock withdrawn mid-operation
      n0 = nreq;
      host_wr(16'h7000, 8'h9C);
      core_lock = 0;
      repeat (3) @(negedge clk);
      chk(core_flash_busy == 1, "R11 busy after lock clear", core_flash_busy, 1);
      wait_idle();
      chk(core_flash_busy == 0 && nreq == n0 + 1, "R11 operation completed", nreq, n0 + 1);
      chk(hreg_rdata == 3'b000, "R11 clean finish", hreg_rdata, 0);

      repeat (4) @(negedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule